// File: doc/BRIEF.md
# Staggered Per-Bank Refresh Scheduler with Command Guard

This block paces per-bank refresh for a memory channel with a parameterised number of banks. Each bank has its own refresh due time. The first due times are spread one clock apart, so bank 0 goes first and each higher bank follows one cycle later. Some cycles before a bank's due time it must be precharged. From that trigger point on, the bank competes for a single refresh request output. The most urgent bank wins, but only when the controller reports that bank as idle. The request is held until the controller signals that the refresh for that same bank has gone out. That service moves the bank's due time forward by exactly one refresh interval, counted from the old due time and not from the moment of service.

The block also drives three guard vectors, one bit per bank, for row activate, read and write. A guard bit tells the command scheduler that a command of that kind, if issued now, would still be in flight when the bank must close for refresh. Each command type has its own look-ahead window ahead of the precharge trigger. A guard stays up through the refresh and is released only once the refresh recovery time has elapsed after service.

Top module: `refresh_sched`

## Requirements
- R1: After reset, bank b's first refresh is due T_REFI - (N - 1) + b cycles after the first active clock edge. With the default parameters, bank b's activate guard therefore first rises in cycle 371 + b.
- R2: A bank becomes pending LEAD = max(N, T_RP) cycles before its due time. A request that is launched for it is visible one cycle later. With the defaults, bank 0's first request appears in cycle 386.
- R3: Servicing a bank moves its due time forward by exactly T_REFI cycles from the previous due time. With the defaults and prompt service, bank 0's second request appears in cycle 786.
- R4: When no request is outstanding, the pending bank with the earliest due time is chosen. Ties go to the lowest index.
- R5: A request is launched only if the chosen bank's idle bit is 1. While that bank is busy, no request is raised, even if other banks are pending.
- R6: A request (req_valid_o = 1, bank index on req_bank_o) stays asserted and keeps the same bank until ref_done_i is 1 with ref_bank_i equal to req_bank_o. It is clear in the next cycle. A strobe that names another bank, or one that arrives while no request is outstanding, changes nothing.
- R7: guard_act_o[b] is 1 from LEAD + T_RAS cycles before bank b's due time until T_RFC cycles after the cycle in which its refresh was serviced.
- R8: guard_rd_o[b] behaves the same way, but its look-ahead is LEAD + T_RTP cycles.
- R9: guard_wr_o[b] behaves the same way, but its look-ahead is LEAD + T_WL + T_CCD + T_WR cycles.
- R10: While reset is asserted and in the first cycle after it, req_valid_o is 0 and all guard bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_idle_i | input | N | One bit per bank; 1 means the bank may start a refresh sequence |
| ref_done_i | input | 1 | Strobe: the per-bank refresh named on ref_bank_i was issued this cycle |
| ref_bank_i | input | $clog2(N) | Bank index that goes with ref_done_i |
| req_valid_o | output | 1 | Refresh request outstanding |
| req_bank_o | output | $clog2(N) | Bank the request is for |
| guard_act_o | output | N | Per-bank block for row activate |
| guard_rd_o | output | N | Per-bank block for read |
| guard_wr_o | output | N | Per-bank block for write |

## Verification
The assertions take for granted that ref_done_i is a single-cycle strobe whose bank index is meaningful only while it is high. They also assume that the controller never services a bank faster than the refresh interval, so a due time is never pushed further than one interval ahead of the current cycle. The stimulus drives the strobe only as a response to an observed request, most often with the requested bank. Now and then it uses a neighbouring index or strobes while no request is outstanding, to exercise the ignore path. Idle bits are drawn at random per bank, with a bias towards idle, so that both blocked and permitted launches occur without the refresh backlog growing without bound.

// File: rtl/refsched_pkg.sv
`timescale 1ns/1ps
package refsched_pkg;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Width of a signed down-counter spanning 0..span with headroom for overdue values.
    function automatic int unsigned cnt_width(input int unsigned span);
        return $clog2(span + 1) + 2;
    endfunction

endpackage

// File: rtl/refsched_bank_timer.sv
`timescale 1ns/1ps
module refsched_bank_timer #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned REC_W    = 5,
    parameter int unsigned INIT_DUE = 400,
    parameter int unsigned T_REFI   = 400,
    parameter int unsigned LEAD     = 8,
    parameter int unsigned THR_ACT  = 22,
    parameter int unsigned THR_RD   = 12,
    parameter int unsigned THR_WR   = 24,
    parameter int unsigned T_RFC    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serviced_i,
    output logic             pending_o,
    output logic [CNT_W-1:0] due_in_o,
    output logic             guard_act_o,
    output logic             guard_rd_o,
    output logic             guard_wr_o
);
    localparam logic [CNT_W-1:0] FLOOR = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] LEAD_S = CNT_W'(LEAD);
    localparam logic signed [CNT_W-1:0] ACT_S  = CNT_W'(THR_ACT);
    localparam logic signed [CNT_W-1:0] RD_S   = CNT_W'(THR_RD);
    localparam logic signed [CNT_W-1:0] WR_S   = CNT_W'(THR_WR);

    typedef struct packed {
        logic [CNT_W-1:0] due_in;   // cycles until refresh due, two's complement
        logic [REC_W-1:0] rec;      // remaining refresh recovery cycles
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.rec != '0) begin
            s_d.rec = s_q.rec - 1'b1;
        end
        if (s_q.due_in != FLOOR) begin
            s_d.due_in = s_q.due_in - 1'b1;
        end
        if (serviced_i) begin
            s_d.due_in = s_q.due_in + CNT_W'(T_REFI - 1);
            s_d.rec    = REC_W'(T_RFC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.due_in <= CNT_W'(INIT_DUE);
            s_q.rec    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign due_in_o    = s_q.due_in;
    assign pending_o   = $signed(s_q.due_in) <= LEAD_S;
    assign guard_act_o = ($signed(s_q.due_in) <= ACT_S) || (s_q.rec != '0);
    assign guard_rd_o  = ($signed(s_q.due_in) <= RD_S)  || (s_q.rec != '0);
    assign guard_wr_o  = ($signed(s_q.due_in) <= WR_S)  || (s_q.rec != '0);

    AST_GUARD_AFTER_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (T_RFC > 1 && serviced_i) |=> (guard_act_o && guard_rd_o && guard_wr_o)); // R7

endmodule

// File: rtl/refsched_pick.sv
`timescale 1ns/1ps
module refsched_pick #(
    parameter int unsigned N     = 8,
    parameter int unsigned CNT_W = 12,
    parameter int unsigned BW    = 3
) (
    input  logic [N-1:0]            pending_i,
    input  logic [N-1:0][CNT_W-1:0] due_i,
    output logic                    found_o,
    output logic [BW-1:0]           idx_o
);
    always_comb begin
        logic             hit;
        logic [BW-1:0]    sel;
        logic [CNT_W-1:0] best;
        hit  = 1'b0;
        sel  = '0;
        best = '0;
        // strict less-than keeps the lowest index on a tie
        for (int b = 0; b < int'(N); b++) begin
            if (pending_i[b] && (!hit || ($signed(due_i[b]) < $signed(best)))) begin
                hit  = 1'b1;
                sel  = BW'(b);
                best = due_i[b];
            end
        end
        found_o = hit;
        idx_o   = sel;
    end
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter int unsigned T_REFI = 400,
    parameter int unsigned T_RP   = 6,
    parameter int unsigned T_RFC  = 20,
    parameter int unsigned T_RAS  = 14,
    parameter int unsigned T_RTP  = 4,
    parameter int unsigned T_WL   = 4,
    parameter int unsigned T_CCD  = 4,
    parameter int unsigned T_WR   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         bank_idle_i,
    input  logic                 ref_done_i,
    input  logic [$clog2(N)-1:0] ref_bank_i,
    output logic                 req_valid_o,
    output logic [$clog2(N)-1:0] req_bank_o,
    output logic [N-1:0]         guard_act_o,
    output logic [N-1:0]         guard_rd_o,
    output logic [N-1:0]         guard_wr_o
);
    localparam int unsigned BW      = $clog2(N);
    localparam int unsigned LEAD    = max_u(N, T_RP);
    localparam int unsigned THR_ACT = LEAD + T_RAS;
    localparam int unsigned THR_RD  = LEAD + T_RTP;
    localparam int unsigned THR_WR  = LEAD + T_WL + T_CCD + T_WR;
    localparam int unsigned CNT_W   = cnt_width(T_REFI + max_u(THR_WR, THR_ACT));
    localparam int unsigned REC_W   = $clog2(T_RFC + 1);

    typedef struct packed {
        logic          valid;
        logic [BW-1:0] bank;
    } req_t;

    req_t                    req_d, req_q;
    logic [N-1:0]            serviced;
    logic [N-1:0]            pending;
    logic [N-1:0][CNT_W-1:0] due_vec;
    logic                    pick_found;
    logic [BW-1:0]           pick_idx;
    logic                    hit;

    for (genvar g = 0; g < int'(N); g++) begin : g_bank
        localparam int unsigned INIT = T_REFI - (N - 1) + g;
        refsched_bank_timer #(
            .CNT_W    (CNT_W),
            .REC_W    (REC_W),
            .INIT_DUE (INIT),
            .T_REFI   (T_REFI),
            .LEAD     (LEAD),
            .THR_ACT  (THR_ACT),
            .THR_RD   (THR_RD),
            .THR_WR   (THR_WR),
            .T_RFC    (T_RFC)
        ) u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .serviced_i  (serviced[g]),
            .pending_o   (pending[g]),
            .due_in_o    (due_vec[g]),
            .guard_act_o (guard_act_o[g]),
            .guard_rd_o  (guard_rd_o[g]),
            .guard_wr_o  (guard_wr_o[g])
        );
    end

    refsched_pick #(
        .N     (N),
        .CNT_W (CNT_W),
        .BW    (BW)
    ) u_pick (
        .pending_i (pending),
        .due_i     (due_vec),
        .found_o   (pick_found),
        .idx_o     (pick_idx)
    );

    always_comb begin
        req_d    = req_q;
        serviced = '0;
        hit      = req_q.valid && ref_done_i && (ref_bank_i == req_q.bank);
        if (hit) begin
            req_d.valid = 1'b0;
            serviced    = N'(1) << req_q.bank;
        end else if (!req_q.valid && pick_found && bank_idle_i[pick_idx]) begin
            req_d.valid = 1'b1;
            req_d.bank  = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_valid_o = req_q.valid;
    assign req_bank_o  = req_q.bank;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !(ref_done_i && ref_bank_i == req_bank_o)) |=> (req_valid_o && $stable(req_bank_o))); // R6

    AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && ref_done_i && ref_bank_i == req_bank_o) |=> !req_valid_o); // R6

    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> |($past(bank_idle_i) & (N'(1) << req_bank_o))); // R5

    AST_GUARD_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (guard_act_o[req_bank_o] && guard_rd_o[req_bank_o] && guard_wr_o[req_bank_o])); // R7, R8, R9

endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int N      = 8;
    localparam int BW     = 3;
    localparam int T_REFI = 400;
    localparam int T_RP   = 6;
    localparam int T_RFC  = 20;
    localparam int T_RAS  = 14;
    localparam int T_RTP  = 4;
    localparam int T_WL   = 4;
    localparam int T_CCD  = 4;
    localparam int T_WR   = 8;
    localparam int LEAD   = (N > T_RP) ? N : T_RP;
    localparam int W_ACT  = LEAD + T_RAS;
    localparam int W_RD   = LEAD + T_RTP;
    localparam int W_WR   = LEAD + T_WL + T_CCD + T_WR;
    localparam int RUN    = 6000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  bank_idle = '1;
    logic          ref_done = 1'b0;
    logic [BW-1:0] ref_bank = '0;
    logic          req_valid;
    logic [BW-1:0] req_bank;
    logic [N-1:0]  g_act, g_rd, g_wr;

    always #10 clk = ~clk;

    refresh_sched #(
        .N(N), .T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC), .T_RAS(T_RAS),
        .T_RTP(T_RTP), .T_WL(T_WL), .T_CCD(T_CCD), .T_WR(T_WR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bank_idle_i(bank_idle), .ref_done_i(ref_done),
        .ref_bank_i(ref_bank), .req_valid_o(req_valid), .req_bank_o(req_bank),
        .guard_act_o(g_act), .guard_rd_o(g_rd), .guard_wr_o(g_wr)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int due [N];
    int free_at [N];
    bit mreq = 1'b0;
    int mbank = 0;
    bit done = 1'b0;
    int first_act [N];
    int b0_rises = 0;
    int b0_rise_at [2];
    bit prev_req = 1'b0;

    // reference model, written from the requirements in absolute cycle numbers
    always @(posedge clk) begin
        if (rst_n) begin : mdl
            int best;
            bit m_hit;
            m_hit = mreq && ref_done && (int'(ref_bank) == mbank);
            best = -1;
            for (int b = 0; b < N; b++)
                if (cyc >= due[b] - LEAD && (best < 0 || due[b] < due[best])) best = b;
            if (m_hit) begin
                due[mbank] += T_REFI;
                free_at[mbank] = cyc + T_RFC;
                mreq = 1'b0;
            end else if (!mreq && best >= 0 && bank_idle[best]) begin
                mreq = 1'b1;
                mbank = best;
            end
            cyc++;
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [N-1:0] ea, er, ew;
        for (int b = 0; b < N; b++) begin
            ea[b] = (cyc >= due[b] - W_ACT) || (cyc < free_at[b]);
            er[b] = (cyc >= due[b] - W_RD)  || (cyc < free_at[b]);
            ew[b] = (cyc >= due[b] - W_WR)  || (cyc < free_at[b]);
        end
        check(req_valid == mreq, "R4 R5 R6", "req_valid", int'(req_valid), int'(mreq));
        if (mreq) check(int'(req_bank) == mbank, "R4", "req_bank", int'(req_bank), mbank);
        check(g_act == ea, "R7", "guard_act", int'(g_act), int'(ea));
        check(g_rd == er, "R8", "guard_rd", int'(g_rd), int'(er));
        check(g_wr == ew, "R9", "guard_wr", int'(g_wr), int'(ew));
    endtask

    task automatic directed_checks();
        for (int b = 0; b < N; b++)
            if (g_act[b] && first_act[b] < 0) first_act[b] = cyc;
        if (req_valid && !prev_req && req_bank == 0 && b0_rises < 2) begin
            b0_rise_at[b0_rises] = cyc;
            b0_rises++;
        end
        prev_req = req_valid;
        if (cyc == 900) begin
            for (int b = 0; b < N; b++)
                check(first_act[b] == T_REFI - (N - 1) + b - W_ACT, "R1", "first act guard rise",
                      first_act[b], T_REFI - (N - 1) + b - W_ACT);
            check(b0_rise_at[0] == 386, "R2", "bank0 first request", b0_rise_at[0], 386);
            check(b0_rise_at[1] == 786, "R3", "bank0 second request", b0_rise_at[1], 786);
        end
        if (cyc == 1195) check(req_valid == 1'b0, "R5", "no launch while earliest bank busy", int'(req_valid), 0);
        if (cyc == 1201) check(req_valid && req_bank == 0, "R5", "launch after idle", int'(req_bank), 0);
        if (cyc == 1204) check(req_valid && req_bank == 0, "R6", "held over wrong strobes", int'(req_valid), 1);
        if (cyc == 1205) check(req_valid == 1'b0, "R6", "clear after matching strobe", int'(req_valid), 0);
        if (cyc == 1223) check(g_act[0] == 1'b1, "R7", "guard during recovery", int'(g_act[0]), 1);
        if (cyc == 1224) check(g_act[0] == 1'b0, "R7", "guard released after recovery", int'(g_act[0]), 0);
    endtask

    task automatic drive();
        ref_done = 1'b0;
        ref_bank = '0;
        if (cyc < 1300) begin
            bank_idle = '1;
            if (cyc >= 1180 && cyc < 1200) bank_idle[0] = 1'b0;
            if (cyc >= 1201 && cyc <= 1203) begin
                ref_done = 1'b1;
                ref_bank = BW'(3);
            end else if (req_valid) begin
                ref_done = 1'b1;
                ref_bank = req_bank;
            end
        end else begin
            for (int b = 0; b < N; b++) bank_idle[b] = ($urandom_range(0, 3) != 0);
            if (req_valid && $urandom_range(0, 2) == 0) begin
                ref_done = 1'b1;
                ref_bank = ($urandom_range(0, 7) == 0) ? BW'(req_bank + 1'b1) : req_bank;
            end else if (!req_valid && $urandom_range(0, 19) == 0) begin
                ref_done = 1'b1;
                ref_bank = BW'($urandom_range(0, N - 1));
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < N; b++) begin
            due[b] = T_REFI - (N - 1) + b;
            free_at[b] = 0;
            first_act[b] = -1;
        end
        b0_rise_at[0] = -1;
        b0_rise_at[1] = -1;
        repeat (3) @(negedge clk);
        check(req_valid == 1'b0, "R10", "req_valid in reset", int'(req_valid), 0);
        check((g_act | g_rd | g_wr) == '0, "R10", "guards in reset", int'(g_act | g_rd | g_wr), 0);
        rst_n = 1'b1;
        check(req_valid == 1'b0 && (g_act | g_rd | g_wr) == '0, "R10", "state after reset",
              int'(req_valid), 0);
        for (int k = 0; k < RUN; k++) begin
            compare_model();
            directed_checks();
            drive();
            @(negedge clk);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(20 * (RUN + 2000));
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete, actual cycle %0d expected %0d", cyc, RUN);
            summary();
            $finish;
        end
    end
endmodule